// File: doc/BRIEF.md
# Prescaled Modulo Timer Timebase

This block is the shared timebase of a timer unit. A 16-bit counter advances on a count step. The step comes from a selectable clock source followed by a power-of-two prescaler. The counter is bounded by a 16-bit modulo value and runs in one of two modes:

- In up-count mode the counter wraps to zero after it reaches the modulo value.
- In center-aligned mode it climbs to the modulo value and then descends back to zero.

An overflow flag records each turnaround. Clearing it takes two steps: a read of the status register, then a write of 0 to the flag bit. The overflow interrupt request is derived from the flag and the interrupt enable.

Software reaches the block through an 8-bit register bus with a 3-bit address:

- Writing either counter byte clears the counter.
- The modulo value is written one byte at a time. While only one byte of a new value has been written, overflow reporting is held off.

A freeze input stops the counter and the prescaler so that the count can be inspected during debug halts.

Top module: `tmb_timebase`

## Requirements
- R1: After reset, every register reads 0x00 and `irq` is low.
- R2: Register addresses are: 0 status/control, 1 counter high byte, 2 counter low byte, 3 modulo high byte, 4 modulo low byte. Addresses 5 to 7 read 0x00. `rd_data` holds the addressed byte in the cycle after `rd_en` is high. In up-count mode each count step adds one to the counter.
- R3: In up-count mode, a count step taken while the counter equals the modulo value returns the counter to 0x0000. The same step sets the overflow flag.
- R4: A modulo value of 0x0000 makes the counter free-running. It passes through every value up to 0xFFFF and sets the overflow flag when it steps from 0xFFFF to 0x0000.
- R5: When the center-align bit is set, the counter counts up to the modulo value and then down to 0x0000, where it turns upward again. The overflow flag sets on the step from the modulo value to the next lower count. Reaching the modulo value does not set it.
- R6: The status/control byte has these fields:
  - bit 7: overflow flag
  - bit 6: interrupt enable
  - bit 5: center-align select
  - bits 4:3: clock source
  - bits 2:0: prescale exponent P

  The counter takes one count step per 2^P source ticks, for P from 0 to 7. Writing a counter byte restarts the prescaler.
- R7: The clock source field selects as follows:
  - 00: no ticks, so the counter stops.
  - 01: one tick per bus clock.
  - 10: one tick per cycle with `fixed_tick` high.
  - 11: one tick per rising edge of `ext_clk`, after a two-flop synchronizer. `ext_clk` must run no faster than a quarter of the bus clock.
- R8: The overflow flag clears only on a write of 0 to bit 7 of address 0 that follows a read of address 0 made while the flag was set. A write without that read leaves the flag set. Writing 1 to bit 7 never sets the flag.
- R9: An overflow occurring between the arming read and the clearing write cancels the clear, and the flag stays set.
- R10: After a write to one modulo byte, overflows do not set the flag and `irq` is held low until the other modulo byte has been written.
- R11: A write of any value to address 1 or 2 clears the whole 16-bit counter.
- R12: `irq` is high one cycle after the overflow flag and the interrupt enable are both set and no modulo byte write is pending.
- R13: While `freeze` is high, the counter holds its value and the prescaler does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Registered read data |
| fixed_tick | input | 1 | Fixed-rate clock enable, one bus cycle per tick |
| ext_clk | input | 1 | Asynchronous external clock |
| freeze | input | 1 | Debug freeze: holds the counter and the prescaler |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench targets the flag clearing sequence in each of its variants:
- a write with no preceding read, which a careless design would honour and so drop the flag;
- a write of 1;
- a second overflow landing between the read and the write, which would be lost if the armed state were not cancelled.

In center-aligned mode it separates reaching the modulo value from leaving it. A design that raises the flag one step early, or that mishandles the turn at zero, shows a wrong count or a wrong status byte.

It also checks the half-written modulo value. A design without the hold-off raises the flag and `irq` during the window.

Prescale counts are checked at exact edge counts, so an off-by-one in the divide mask shows up as a wrong count.

// File: rtl/tmb_pkg.sv
package tmb_pkg;

  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_CNT_HI = 3'd1,
    A_CNT_LO = 3'd2,
    A_MOD_HI = 3'd3,
    A_MOD_LO = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    SRC_OFF   = 2'd0,
    SRC_BUS   = 2'd1,
    SRC_FIXED = 2'd2,
    SRC_EXT   = 2'd3
  } clk_src_e;

endpackage

// File: rtl/tmb_src_sel.sv
module tmb_src_sel
  import tmb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  clk_src_e src,
  input  logic     fixed_tick,
  input  logic     ext_clk,
  output logic     tick
);

  // synchronizer chain plus one history flop for edge detection
  logic [SYNC_STAGES:0] sh;
  logic                 ext_rise;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC_STAGES-1:0], ext_clk};
  end

  assign ext_rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];

  always_comb begin
    case (src)
      SRC_BUS:   tick = 1'b1;
      SRC_FIXED: tick = fixed_tick;
      SRC_EXT:   tick = ext_rise;
      default:   tick = 1'b0;
    endcase
  end

  // R7: a synchronized edge yields a single-cycle pulse
  p_ext_single_r7: assert property (@(posedge clk) disable iff (rst)
    ext_rise |=> !ext_rise);

endmodule

// File: rtl/tmb_prescaler.sv
module tmb_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            hold,
  input  logic            restart,
  input  logic [PS_W-1:0] ps,
  output logic            step
);

  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] pcnt;
  logic [DIV_W-1:0] mask;
  logic             adv;

  // 1 << ps wraps to zero at the top exponent, so the subtraction still gives all ones
  assign mask = (DIV_W'(1) << ps) - DIV_W'(1);
  assign adv  = tick & ~hold;
  assign step = adv & ((pcnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || restart) pcnt <= '0;
    else if (adv)       pcnt <= pcnt + DIV_W'(1);
  end

  // R6: with a divisor of two or more, steps never come back to back
  p_div_gap_r6: assert property (@(posedge clk) disable iff (rst)
    (step && ps != '0 && !restart) |=> (!step || ps != $past(ps)));

  // R13: a held prescaler keeps its phase
  p_hold_phase_r13: assert property (@(posedge clk) disable iff (rst)
    (hold && !restart) |=> $stable(pcnt));

endmodule

// File: rtl/tmb_counter.sv
module tmb_counter
  import tmb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             clear,
  input  logic             center,
  input  logic [CNT_W-1:0] modv,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] nxt;
  logic             down;
  logic             ndown;
  logic             turn;

  assign lim = (modv == '0) ? '1 : modv;

  always_comb begin
    nxt   = cnt;
    ndown = center ? down : 1'b0;
    turn  = 1'b0;
    if (step) begin
      if (!center) begin
        if (cnt == lim) begin
          nxt  = '0;
          turn = 1'b1;
        end else begin
          nxt = cnt + CNT_W'(1);
        end
      end else if (!down) begin
        if (cnt >= lim) begin
          nxt   = cnt - CNT_W'(1);
          ndown = 1'b1;
          turn  = 1'b1;
        end else begin
          nxt = cnt + CNT_W'(1);
        end
      end else begin
        if (cnt == '0) begin
          nxt   = CNT_W'(1);
          ndown = 1'b0;
        end else begin
          nxt = cnt - CNT_W'(1);
        end
      end
    end
  end

  assign wrap = turn & ~clear;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt  <= '0;
      down <= 1'b0;
    end else begin
      cnt  <= nxt;
      down <= ndown;
    end
  end

  // R2: an up-count step below the limit adds exactly one
  p_up_step_r2: assert property (@(posedge clk) disable iff (rst)
    (step && !center && !clear && cnt != lim) |=> cnt == $past(cnt) + CNT_W'(1));

  // R3: an up-count step at the limit lands on zero
  p_up_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !center && !clear && cnt == lim) |=> cnt == '0);

  // R5: a descending step at zero turns the counter upward at one
  p_bounce_r5: assert property (@(posedge clk) disable iff (rst)
    (step && center && !clear && down && cnt == '0) |=> (cnt == CNT_W'(1) && !down));

  // R11: a clear request empties the counter
  p_clear_r11: assert property (@(posedge clk) disable iff (rst)
    clear |=> cnt == '0);

endmodule

// File: rtl/tmb_timebase.sv
module tmb_timebase
  import tmb_pkg::*;
#(
  parameter int PS_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       fixed_tick,
  input  logic       ext_clk,
  input  logic       freeze,
  output logic       irq
);

  localparam int CTRL_FLAG = 7;
  localparam int CTRL_IE   = 6;
  localparam int CTRL_CTR  = 5;
  localparam int SRC_LSB   = 3;

  logic             ovf_flag;
  logic             ovf_ie;
  logic             center;
  clk_src_e         src;
  logic [PS_W-1:0]  ps;
  logic             armed;
  logic             hi_pend;
  logic             lo_pend;
  logic [CNT_W-1:0] modv;
  logic [CNT_W-1:0] cnt_val;
  logic             tick;
  logic             step;
  logic             wrap;
  logic             inhibit;
  logic             set_flag;
  logic             ctrl_wr;
  logic             cnt_wr;
  logic             ctrl_rd;
  logic [7:0]       status;

  assign ctrl_wr  = wr_en && (addr == A_CTRL);
  assign cnt_wr   = wr_en && (addr == A_CNT_HI || addr == A_CNT_LO);
  assign ctrl_rd  = rd_en && (addr == A_CTRL);
  assign inhibit  = hi_pend | lo_pend;
  assign set_flag = wrap & ~inhibit;

  tmb_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk        (clk),
    .rst        (rst),
    .src        (src),
    .fixed_tick (fixed_tick),
    .ext_clk    (ext_clk),
    .tick       (tick)
  );

  tmb_prescaler #(.PS_W(PS_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .hold    (freeze),
    .restart (cnt_wr),
    .ps      (ps),
    .step    (step)
  );

  tmb_counter u_cnt (
    .clk    (clk),
    .rst    (rst),
    .step   (step),
    .clear  (cnt_wr),
    .center (center),
    .modv   (modv),
    .cnt    (cnt_val),
    .wrap   (wrap)
  );

  // control fields
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_ie <= 1'b0;
      center <= 1'b0;
      src    <= SRC_OFF;
      ps     <= '0;
    end else if (ctrl_wr) begin
      ovf_ie <= wr_data[CTRL_IE];
      center <= wr_data[CTRL_CTR];
      src    <= clk_src_e'(wr_data[SRC_LSB +: 2]);
      ps     <= wr_data[PS_W-1:0];
    end
  end

  // overflow flag with its read-then-write-0 clearing sequence
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (set_flag)
        ovf_flag <= 1'b1;
      else if (ctrl_wr && armed && !wr_data[CTRL_FLAG])
        ovf_flag <= 1'b0;

      if (wrap || ctrl_wr) armed <= 1'b0;
      else if (ctrl_rd && ovf_flag) armed <= 1'b1;
    end
  end

  // modulo bytes and the half-written hold-off
  always_ff @(posedge clk) begin
    if (rst) begin
      modv    <= '0;
      hi_pend <= 1'b0;
      lo_pend <= 1'b0;
    end else if (wr_en && addr == A_MOD_HI) begin
      modv[CNT_W-1:BYTE_W] <= wr_data;
      if (lo_pend) lo_pend <= 1'b0;
      else         hi_pend <= 1'b1;
    end else if (wr_en && addr == A_MOD_LO) begin
      modv[BYTE_W-1:0] <= wr_data;
      if (hi_pend) hi_pend <= 1'b0;
      else         lo_pend <= 1'b1;
    end
  end

  assign status = {ovf_flag, ovf_ie, center, src, ps};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= ovf_flag & ovf_ie & ~inhibit;
      if (rd_en) begin
        case (addr)
          A_CTRL:   rd_data <= status;
          A_CNT_HI: rd_data <= cnt_val[CNT_W-1:BYTE_W];
          A_CNT_LO: rd_data <= cnt_val[BYTE_W-1:0];
          A_MOD_HI: rd_data <= modv[CNT_W-1:BYTE_W];
          A_MOD_LO: rd_data <= modv[BYTE_W-1:0];
          default:  rd_data <= '0;
        endcase
      end
    end
  end

  // R8: the flag only rises on an overflow event
  p_no_spurious_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (!ovf_flag && !set_flag) |=> !ovf_flag);

  // R8: without an armed status write the flag persists
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !(ctrl_wr && armed)) |=> ovf_flag);

  // R10: a pending modulo byte blocks the flag
  p_mod_holdoff_r10: assert property (@(posedge clk) disable iff (rst)
    (inhibit && !ovf_flag) |=> !ovf_flag);

  // R12: the request follows the flag and the enable
  p_irq_source_r12: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ovf_flag && ovf_ie));

  // R13: a frozen counter keeps its value
  p_freeze_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (freeze && !cnt_wr) |=> $stable(cnt_val));

endmodule

// File: tb/sim_tmb_timebase.sv
`timescale 1ns/1ps
module sim_tmb_timebase;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       fixed_tick = 1'b0;
  logic       ext_clk = 1'b0;
  logic       freeze = 1'b1;
  logic       irq;

  int tests = 0;
  int fails = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_t;

  exp_t sb[$];
  logic rd_seen = 1'b0;

  always #10 clk = ~clk;

  tmb_timebase u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .fixed_tick(fixed_tick),
    .ext_clk(ext_clk), .freeze(freeze), .irq(irq)
  );

  // monitor: a read strobe at an edge leaves its data valid until the next read
  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      tests++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL scoreboard empty: read data %h with no expectation", rd_data);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rd_data !== e.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", e.tag, rd_data, e.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    exp_t it;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    addr = a; rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic run(input int n);
    freeze = 1'b0;
    repeat (n) @(posedge clk);
    #1 freeze = 1'b1;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    tests++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: actual irq %b expected %b", tag, irq, e);
    end
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    rd(3'd0, 8'h00, "R1 status");
    rd(3'd1, 8'h00, "R1 count hi");
    rd(3'd2, 8'h00, "R1 count lo");
    rd(3'd3, 8'h00, "R1 mod hi");
    rd(3'd4, 8'h00, "R1 mod lo");
    chk_irq(1'b0, "R1 irq");

    // R2 up counting on bus clock, modulo 10
    wr(3'd3, 8'h00); wr(3'd4, 8'h0A);
    wr(3'd0, 8'h08); wr(3'd2, 8'h00);
    run(7);
    rd(3'd2, 8'h07, "R2 count after 7 steps");
    rd(3'd1, 8'h00, "R2 count hi");
    rd(3'd5, 8'h00, "R2 unused address");

    // R3 wrap at the modulo value
    run(4);
    rd(3'd0, 8'h88, "R3 flag after wrap");
    rd(3'd2, 8'h00, "R3 count back at zero");

    // R8 clearing sequence
    wr(3'd0, 8'h08);
    rd(3'd0, 8'h08, "R8 cleared after read then write 0");
    run(11);
    wr(3'd0, 8'h08);
    rd(3'd0, 8'h88, "R8 write 0 without read ignored");
    wr(3'd0, 8'h88);
    rd(3'd0, 8'h88, "R8 write 1 does not clear");
    wr(3'd0, 8'h08);
    rd(3'd0, 8'h08, "R8 clear after fresh read");
    wr(3'd0, 8'h88);
    rd(3'd0, 8'h08, "R8 write 1 does not set");

    // R9 new overflow between read and write
    run(11);
    rd(3'd0, 8'h88, "R9 flag set");
    run(11);
    wr(3'd0, 8'h08);
    rd(3'd0, 8'h88, "R9 flag kept after intervening overflow");
    wr(3'd0, 8'h08);
    rd(3'd0, 8'h08, "R9 later clear works");

    // R11 counter write clears
    run(5);
    rd(3'd2, 8'h05, "R11 count before clear");
    wr(3'd1, 8'h55);
    rd(3'd2, 8'h00, "R11 count lo cleared");
    rd(3'd1, 8'h00, "R11 count hi cleared");

    // R6 prescaler
    wr(3'd0, 8'h0A); wr(3'd2, 8'h00);
    run(12);
    rd(3'd2, 8'h03, "R6 divide by 4 after 12 edges");
    run(1);
    rd(3'd2, 8'h03, "R6 divide by 4 no early step");
    wr(3'd0, 8'h09); wr(3'd2, 8'h00);
    run(6);
    rd(3'd2, 8'h03, "R6 divide by 2 after 6 edges");

    // R7 clock sources
    wr(3'd0, 8'h00);
    run(20);
    rd(3'd2, 8'h03, "R7 source off holds");
    wr(3'd0, 8'h10);
    freeze = 1'b0;
    for (int i = 0; i < 3; i++) begin
      fixed_tick = 1'b1; @(posedge clk); #1;
      fixed_tick = 1'b0; @(posedge clk); #1;
    end
    freeze = 1'b1;
    rd(3'd2, 8'h06, "R7 fixed tick source");
    wr(3'd0, 8'h18);
    freeze = 1'b0;
    for (int i = 0; i < 3; i++) begin
      ext_clk = 1'b1; repeat (4) @(posedge clk); #1;
      ext_clk = 1'b0; repeat (4) @(posedge clk); #1;
    end
    repeat (4) @(posedge clk); #1;
    freeze = 1'b1;
    rd(3'd2, 8'h09, "R7 external source edges");

    // R13 freeze
    wr(3'd0, 8'h08);
    repeat (20) @(posedge clk); #1;
    rd(3'd2, 8'h09, "R13 frozen count");

    // R10 half-written modulo
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);
    run(11);
    rd(3'd0, 8'h08, "R10 no flag while modulo half written");
    rd(3'd2, 8'h00, "R10 counter still wrapped");
    wr(3'd4, 8'h0A);
    run(11);
    rd(3'd0, 8'h88, "R10 flag after modulo completed");

    // R12 interrupt request
    wr(3'd0, 8'hC8);
    @(posedge clk); #1;
    chk_irq(1'b1, "R12 irq with flag and enable");
    wr(3'd0, 8'h88);
    @(posedge clk); #1;
    chk_irq(1'b0, "R12 irq low with enable off");
    wr(3'd0, 8'hC8);
    @(posedge clk); #1;
    wr(3'd3, 8'h00);
    @(posedge clk); #1;
    chk_irq(1'b0, "R10 irq held while modulo pending");
    wr(3'd4, 8'h0A);
    @(posedge clk); #1;
    chk_irq(1'b1, "R12 irq back after modulo completed");

    // R5 center-aligned
    rd(3'd0, 8'hC8, "R5 status before center mode");
    wr(3'd0, 8'h28);
    wr(3'd3, 8'h00); wr(3'd4, 8'h04); wr(3'd2, 8'h00);
    run(4);
    rd(3'd0, 8'h28, "R5 no flag on reaching top");
    rd(3'd2, 8'h04, "R5 at top");
    run(1);
    rd(3'd2, 8'h03, "R5 first down step");
    rd(3'd0, 8'hA8, "R5 flag on leaving top");
    run(3);
    rd(3'd2, 8'h00, "R5 at bottom");
    run(1);
    rd(3'd2, 8'h01, "R5 turned upward");

    // R4 free-running with modulo zero
    wr(3'd0, 8'h08);
    wr(3'd3, 8'h00); wr(3'd4, 8'h00); wr(3'd2, 8'h00);
    run(300);
    rd(3'd1, 8'h01, "R4 free run hi");
    rd(3'd2, 8'h2C, "R4 free run lo");
    rd(3'd0, 8'h08, "R4 no flag mid range");
    run(65236);
    rd(3'd0, 8'h88, "R4 flag at full-range wrap");
    rd(3'd2, 8'h00, "R4 count wrapped to zero");

    repeat (3) @(posedge clk);
    tests++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule